// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block is the host side of a three-wire link to a 16-bit serial converter. A start request pulls the active-low chip select down, and the block then makes a serial clock from the system clock by a parameterised divider. Over one frame it produces exactly twenty-four clock pulses. It takes one data sample at each rising serial-clock edge. The converter drives a new bit after each falling edge, and the level it drives as chip select falls is the first sample.

The first eight samples are leading bits that should read zero. The block only checks them and raises a flag if any is one. The remaining sixteen samples make up the result, most significant bit first. When the frame ends, chip select returns high in the same cycle as a one-cycle valid strobe.

After chip select rises, it stays high for at least a programmable number of cycles before the next frame may begin. A start request that arrives during a frame or during that gap is remembered and served as soon as the gap ends. An abort input ends a frame at once and no result is reported for it.

Top module: `adc_rd_ctrl`

## Requirements
- R1: While reset is high and after it is released, chip select is high, the serial clock is low, busy is low and result_valid is low.
- R2: A start request seen in an idle cycle drives chip select low at the next clock edge. The serial clock then stays low for HALF_CYC cycles before its first rising edge, and chip select stays low for the whole frame.
- R3: A complete frame has exactly 24 serial-clock pulses. Every high phase and every low phase lasts HALF_CYC system cycles, including the initial low phase and the low phase after the 24th falling edge.
- R4: Samples 0 to 7 (taken at rising edges 1 to 8) are leading bits. Samples 8 to 23 form result_o with sample 8 as bit 15 and sample 23 as bit 0. result_o holds its value until the next completed frame.
- R5: When the low phase after the 24th pulse ends, chip select rises, and result_valid is high for exactly that one cycle.
- R6: lead_err_o updates together with result_valid. It is 1 when any of the eight leading samples was 1, and 0 otherwise.
- R7: Between any chip-select rise and the next fall, chip select stays high for at least GAP_CYC cycles. When a request is already waiting, it stays high for exactly GAP_CYC cycles.
- R8: An abort while chip select is low drives chip select high and the serial clock low at the next edge. No result_valid follows, result_o keeps its previous value, and the gap of R7 applies. Abort takes priority even in the cycle in which the frame would complete.
- R9: A start request that arrives during a frame or during the gap is held, including across an abort. It is served by exactly one further frame, however many requests arrived in that time.
- R10: busy_o is high from the cycle after a frame launches until the gap after it has expired with no request waiting.
- R11: An abort while chip select is high has no effect: chip select stays high and busy stays low.
- R12: The serial clock is low in every cycle in which chip select is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request for one conversion frame |
| abort_i | input | 1 | Ends the current frame without a result |
| sdo_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip select to the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| busy_o | output | 1 | Frame or chip-select gap in progress |
| result_o | output | DATA_BITS | Last completed conversion result |
| result_valid_o | output | 1 | One-cycle strobe marking a new result |
| lead_err_o | output | 1 | A leading bit of the last frame read as one |

## Verification
Two pairs of events can fall in the same cycle. The first is frame completion and abort: the bench raises abort so that it is sampled at exactly the edge that ends the 24th low phase. It then requires chip select to rise with no valid strobe and an unchanged result. The second is gap expiry and a waiting request: the bench queues requests during a frame and during a gap. It then measures the chip-select-high run, which must equal GAP_CYC exactly, and counts the valid strobes, so that a lost or duplicated request shows up as a wrong frame count.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_HIGH  = 3'd2,
    ST_LOW   = 3'd3,
    ST_GAP   = 3'd4
  } rd_state_t;

endpackage

// File: rtl/adc_phase_timer.sv
module adc_phase_timer #(
  parameter int HALF_CYC = 21
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  output logic tick
);
  localparam int PH_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(HALF_CYC - 1);

  logic [PH_W-1:0] cnt_q;

  assign tick = (cnt_q == PH_LAST);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/adc_gap_timer.sv
module adc_gap_timer #(
  parameter int GAP_CYC = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic zero
);
  localparam int GP_W = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
  localparam logic [GP_W-1:0] GP_INIT = GP_W'(GAP_CYC - 1);

  logic [GP_W-1:0] cnt_q;

  assign zero = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= GP_INIT;
    end else if (!zero) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/adc_frame_shift.sv
module adc_frame_shift #(
  parameter int LEAD_BITS = 8,
  parameter int DATA_BITS = 16,
  parameter int IDX_W     = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sample_en,
  input  logic [IDX_W-1:0]     idx,
  input  logic                 sdo_i,
  input  logic                 finish,
  output logic [DATA_BITS-1:0] result_o,
  output logic                 lead_err_o,
  output logic                 valid_o
);
  localparam logic [IDX_W-1:0] LEAD_L = IDX_W'(LEAD_BITS);

  logic [DATA_BITS-1:0] shreg_q;
  logic                 lead_acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q    <= '0;
      lead_acc_q <= 1'b0;
    end else if (sample_en) begin
      if (idx < LEAD_L) begin
        lead_acc_q <= (idx == '0) ? sdo_i : (lead_acc_q | sdo_i);
      end else begin
        shreg_q <= {shreg_q[DATA_BITS-2:0], sdo_i};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o   <= '0;
      lead_err_o <= 1'b0;
      valid_o    <= 1'b0;
    end else begin
      valid_o <= finish;
      if (finish) begin
        result_o   <= shreg_q;
        lead_err_o <= lead_acc_q;
      end
    end
  end
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int HALF_CYC  = 21,
  parameter int GAP_CYC   = 20,
  parameter int LEAD_BITS = 8,
  parameter int DATA_BITS = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic                 abort_i,
  input  logic                 sdo_i,
  output logic                 cs_n_o,
  output logic                 sclk_o,
  output logic                 busy_o,
  output logic [DATA_BITS-1:0] result_o,
  output logic                 result_valid_o,
  output logic                 lead_err_o
);
  localparam int TOTAL = LEAD_BITS + DATA_BITS;
  localparam int IDX_W = $clog2(TOTAL + 1);
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(TOTAL);

  rd_state_t        state_q;
  logic [IDX_W-1:0] idx_q;
  logic             pend_q;
  logic             ph_tick;
  logic             gap_zero;
  logic             in_frame;
  logic             launch;
  logic             abort_hit;
  logic             finish;
  logic             sample_en;
  logic             gap_load;

  assign in_frame  = (state_q == ST_SETUP) || (state_q == ST_HIGH) || (state_q == ST_LOW);
  assign launch    = (start_i || pend_q) &&
                     ((state_q == ST_IDLE) || ((state_q == ST_GAP) && gap_zero));
  assign abort_hit = abort_i && in_frame;
  assign finish    = !abort_i && ph_tick && (state_q == ST_LOW) && (idx_q == IDX_END);
  assign sample_en = !abort_i && ph_tick &&
                     ((state_q == ST_SETUP) || ((state_q == ST_LOW) && (idx_q != IDX_END)));
  assign gap_load  = abort_hit || finish;
  assign busy_o    = (state_q != ST_IDLE);

  adc_phase_timer #(.HALF_CYC(HALF_CYC)) u_phase (
    .clk   (clk),
    .rst   (rst),
    .clear (!in_frame),
    .tick  (ph_tick)
  );

  adc_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk  (clk),
    .rst  (rst),
    .load (gap_load),
    .zero (gap_zero)
  );

  adc_frame_shift #(
    .LEAD_BITS (LEAD_BITS),
    .DATA_BITS (DATA_BITS),
    .IDX_W     (IDX_W)
  ) u_shift (
    .clk        (clk),
    .rst        (rst),
    .sample_en  (sample_en),
    .idx        (idx_q),
    .sdo_i      (sdo_i),
    .finish     (finish),
    .result_o   (result_o),
    .lead_err_o (lead_err_o),
    .valid_o    (result_valid_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
    end else if (launch) begin
      pend_q <= 1'b0;
    end else if (start_i) begin
      pend_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cs_n_o  <= 1'b1;
      sclk_o  <= 1'b0;
      idx_q   <= '0;
    end else if (abort_hit) begin
      state_q <= ST_GAP;
      cs_n_o  <= 1'b1;
      sclk_o  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (launch) begin
            state_q <= ST_SETUP;
            cs_n_o  <= 1'b0;
            idx_q   <= '0;
          end
        end
        ST_SETUP: begin
          if (ph_tick) begin
            state_q <= ST_HIGH;
            sclk_o  <= 1'b1;
            idx_q   <= idx_q + 1'b1;
          end
        end
        ST_HIGH: begin
          if (ph_tick) begin
            state_q <= ST_LOW;
            sclk_o  <= 1'b0;
          end
        end
        ST_LOW: begin
          if (ph_tick) begin
            if (idx_q == IDX_END) begin
              state_q <= ST_GAP;
              cs_n_o  <= 1'b1;
            end else begin
              state_q <= ST_HIGH;
              sclk_o  <= 1'b1;
              idx_q   <= idx_q + 1'b1;
            end
          end
        end
        ST_GAP: begin
          if (gap_zero) begin
            if (launch) begin
              state_q <= ST_SETUP;
              cs_n_o  <= 1'b0;
              idx_q   <= '0;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: begin
          state_q <= ST_IDLE;
          cs_n_o  <= 1'b1;
          sclk_o  <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/adc_rd_ctrl_chk.sv
module adc_rd_ctrl_chk #(
  parameter int GAP_CYC = 20,
  parameter int TOTAL   = 24
) (
  input logic clk,
  input logic rst,
  input logic start_i,
  input logic abort_i,
  input logic cs_n_o,
  input logic sclk_o,
  input logic busy_o,
  input logic result_valid_o
);
  localparam int HW = $clog2(GAP_CYC + 2);
  localparam int RW = $clog2(TOTAL + 2);
  localparam logic [HW-1:0] GAP_L   = HW'(GAP_CYC);
  localparam logic [RW-1:0] TOTAL_L = RW'(TOTAL);

  logic [HW-1:0] hi_cnt;
  logic [RW-1:0] rise_cnt;
  logic          sclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt   <= GAP_L;
      rise_cnt <= '0;
      sclk_q   <= 1'b0;
    end else begin
      sclk_q <= sclk_o;
      if (cs_n_o) begin
        if (hi_cnt != GAP_L) hi_cnt <= hi_cnt + 1'b1;
        rise_cnt <= '0;
      end else begin
        hi_cnt <= '0;
        if (sclk_o && !sclk_q) rise_cnt <= rise_cnt + 1'b1;
      end
    end
  end

  p_launch_r2: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> (busy_o && !cs_n_o));

  p_pulse_count_r3: assert property (@(posedge clk) disable iff (rst)
    result_valid_o |-> (rise_cnt == TOTAL_L));

  p_valid_single_r5: assert property (@(posedge clk) disable iff (rst)
    result_valid_o |=> !result_valid_o);

  p_valid_cs_rise_r5: assert property (@(posedge clk) disable iff (rst)
    result_valid_o |-> $rose(cs_n_o));

  p_gap_min_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n_o) |-> (hi_cnt >= GAP_L));

  p_abort_frame_r8: assert property (@(posedge clk) disable iff (rst)
    (abort_i && !cs_n_o) |=> (cs_n_o && !sclk_o && !result_valid_o));

  p_abort_idle_r11: assert property (@(posedge clk) disable iff (rst)
    (abort_i && !busy_o && !start_i) |=> (cs_n_o && !busy_o));

  p_sclk_parked_r12: assert property (@(posedge clk) disable iff (rst)
    cs_n_o |-> !sclk_o);
endmodule

bind adc_rd_ctrl adc_rd_ctrl_chk #(
  .GAP_CYC (GAP_CYC),
  .TOTAL   (LEAD_BITS + DATA_BITS)
) chk_i (
  .clk            (clk),
  .rst            (rst),
  .start_i        (start_i),
  .abort_i        (abort_i),
  .cs_n_o         (cs_n_o),
  .sclk_o         (sclk_o),
  .busy_o         (busy_o),
  .result_valid_o (result_valid_o)
);

// File: tb/adc_rd_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_rd_ctrl_tb_top;
  localparam int HALF  = 3;
  localparam int GAP   = 7;
  localparam int FRAME = HALF * 49;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        abort_i = 1'b0;
  logic        sdo_i = 1'b0;
  logic        cs_n_o, sclk_o, busy_o, result_valid_o, lead_err_o;
  logic [15:0] result_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  adc_rd_ctrl #(.HALF_CYC(HALF), .GAP_CYC(GAP), .LEAD_BITS(8), .DATA_BITS(16)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .abort_i(abort_i), .sdo_i(sdo_i),
    .cs_n_o(cs_n_o), .sclk_o(sclk_o), .busy_o(busy_o), .result_o(result_o),
    .result_valid_o(result_valid_o), .lead_err_o(lead_err_o)
  );

  // Converter model: a new bit after chip-select fall and after each falling sclk edge
  logic [15:0] adc_word = '0;
  logic [7:0]  adc_lead = '0;
  int          bit_k = 0;
  bit          in_frame = 1'b0;

  always @(negedge cs_n_o or negedge sclk_o or posedge cs_n_o) begin
    if (cs_n_o) begin
      in_frame = 1'b0;
      sdo_i = 1'b0;
    end else begin
      if (!in_frame) begin
        in_frame = 1'b1;
        bit_k = 0;
      end else begin
        bit_k++;
      end
      if (bit_k < 8)       sdo_i = adc_lead[7 - bit_k];
      else if (bit_k < 24) sdo_i = adc_word[23 - bit_k];
      else                 sdo_i = 1'b0;
    end
  end

  // Port monitor, sampled at the falling system-clock edge
  int  cs_run = 0, sclk_run = 0, pulses = 0;
  int  last_gap = 0, last_pulses = 0, valid_cnt = 0;
  int  bad_phase = 0, bad_valid = 0, bad_idle = 0;
  bit  cs_q = 1'b1, sclk_q = 1'b0;

  always @(negedge clk) begin
    if (rst) begin
      cs_q = 1'b1; sclk_q = 1'b0; cs_run = 0;
    end else begin
      if (cs_n_o != cs_q) begin
        if (!cs_n_o) begin
          last_gap = cs_run;
        end else begin
          last_pulses = pulses;
          if (pulses == 24 && sclk_run != HALF) bad_phase++;
        end
        cs_run = 1;
      end else begin
        cs_run++;
      end
      if (!cs_n_o) begin
        if (cs_q) begin
          pulses = 0; sclk_run = 1;
        end else if (sclk_o != sclk_q) begin
          if (sclk_run != HALF) bad_phase++;
          sclk_run = 1;
          if (sclk_o) pulses++;
        end else begin
          sclk_run++;
        end
      end
      if (result_valid_o) begin
        valid_cnt++;
        if (!(cs_n_o && !cs_q)) bad_valid++;
      end
      if (cs_n_o && sclk_o) bad_idle++;
      cs_q = cs_n_o; sclk_q = sclk_o;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #3;
  endtask

  task automatic pulse_start();
    start_i = 1'b1; tick(); start_i = 1'b0;
  endtask

  task automatic wait_valid(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 4 * FRAME; i++) begin
      if (result_valid_o) begin seen = 1'b1; break; end
      tick();
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4 * FRAME; i++) begin
      if (!busy_o) break;
      tick();
    end
  endtask

  task automatic t_reset();
    chk(cs_n_o == 1'b1, "R1 cs_n after reset", cs_n_o, 1);
    chk(sclk_o == 1'b0, "R1 sclk after reset", sclk_o, 0);
    chk(busy_o == 1'b0, "R1 busy after reset", busy_o, 0);
    chk(result_valid_o == 1'b0, "R1 valid after reset", result_valid_o, 0);
  endtask

  task automatic t_single(input logic [15:0] w, input logic [7:0] ld);
    bit seen;
    wait_idle();
    adc_word = w; adc_lead = ld;
    pulse_start();
    chk(cs_n_o == 1'b0, "R2 cs low after start", cs_n_o, 0);
    chk(busy_o == 1'b1, "R10 busy after launch", busy_o, 1);
    chk(sclk_o == 1'b0, "R2 sclk low in setup", sclk_o, 0);
    wait_valid(seen);
    chk(seen, "R5 valid strobe seen", seen, 1);
    chk(cs_n_o == 1'b1, "R5 cs high with valid", cs_n_o, 1);
    chk(result_o == w, "R4 result word", result_o, w);
    chk(lead_err_o == (ld != 0), "R6 leading-bit flag", lead_err_o, ld != 0);
    chk(last_pulses == 24, "R3 pulses per frame", last_pulses, 24);
    tick();
    chk(result_valid_o == 1'b0, "R5 valid one cycle", result_valid_o, 0);
    chk(result_o == w, "R4 result held", result_o, w);
    chk(busy_o == 1'b1, "R10 busy during gap", busy_o, 1);
  endtask

  task automatic t_gap_request();
    bit seen;
    int v0;
    wait_idle();
    adc_word = 16'h3C5A; adc_lead = 8'h00;
    pulse_start();
    wait_valid(seen);
    pulse_start();
    v0 = valid_cnt;
    wait_valid(seen);
    chk(seen && valid_cnt == v0 + 1, "R9 request in gap served", valid_cnt, v0 + 1);
    chk(last_gap == GAP, "R7 exact gap with waiting request", last_gap, GAP);
  endtask

  task automatic t_back_to_back();
    int v0;
    wait_idle();
    adc_word = 16'h1357; adc_lead = 8'h00;
    v0 = valid_cnt;
    pulse_start();
    repeat (20) tick();
    pulse_start();
    repeat (10) tick();
    pulse_start();
    repeat (FRAME + 2) tick();
    chk(busy_o == 1'b1, "R10 busy between queued frames", busy_o, 1);
    repeat (2 * FRAME) tick();
    chk(valid_cnt == v0 + 2, "R9 requests collapse to one extra frame", valid_cnt, v0 + 2);
    chk(last_gap == GAP, "R7 back-to-back gap", last_gap, GAP);
    chk(busy_o == 1'b0, "R10 busy clears when idle", busy_o, 0);
    chk(result_o == 16'h1357, "R4 queued frame result", result_o, 16'h1357);
  endtask

  task automatic t_abort_mid();
    int v0;
    logic [15:0] r0;
    wait_idle();
    r0 = result_o; v0 = valid_cnt;
    adc_word = 16'hDEAD; adc_lead = 8'h00;
    pulse_start();
    repeat (40) tick();
    abort_i = 1'b1; tick(); abort_i = 1'b0;
    chk(cs_n_o == 1'b1, "R8 cs high after abort", cs_n_o, 1);
    chk(sclk_o == 1'b0, "R8 sclk low after abort", sclk_o, 0);
    repeat (FRAME + GAP) tick();
    chk(valid_cnt == v0, "R8 no valid after abort", valid_cnt, v0);
    chk(result_o == r0, "R8 result kept after abort", result_o, r0);
  endtask

  task automatic t_abort_last_edge();
    int v0;
    logic [15:0] r0;
    wait_idle();
    r0 = result_o; v0 = valid_cnt;
    adc_word = 16'hBEEF; adc_lead = 8'h00;
    pulse_start();
    repeat (FRAME - 1) tick();
    abort_i = 1'b1; tick(); abort_i = 1'b0;
    chk(cs_n_o == 1'b1, "R8 cs high at completion abort", cs_n_o, 1);
    chk(result_valid_o == 1'b0, "R8 abort beats completion", result_valid_o, 0);
    repeat (GAP + 4) tick();
    chk(valid_cnt == v0, "R8 no late valid", valid_cnt, v0);
    chk(result_o == r0, "R8 result unchanged at completion abort", result_o, r0);
  endtask

  task automatic t_abort_pending();
    bit seen;
    int v0;
    wait_idle();
    v0 = valid_cnt;
    adc_word = 16'h0F0F; adc_lead = 8'h00;
    pulse_start();
    repeat (15) tick();
    pulse_start();
    repeat (15) tick();
    abort_i = 1'b1; tick(); abort_i = 1'b0;
    wait_valid(seen);
    chk(seen && valid_cnt == v0 + 1, "R9 request kept across abort", valid_cnt, v0 + 1);
    chk(last_gap == GAP, "R7 gap after abort", last_gap, GAP);
    chk(result_o == 16'h0F0F, "R4 result after aborted frame", result_o, 16'h0F0F);
  endtask

  task automatic t_abort_idle();
    wait_idle();
    repeat (3) tick();
    abort_i = 1'b1; tick(); abort_i = 1'b0;
    chk(cs_n_o == 1'b1, "R11 cs stays high on idle abort", cs_n_o, 1);
    chk(busy_o == 1'b0, "R11 busy stays low on idle abort", busy_o, 0);
    tick();
    chk(busy_o == 1'b0, "R11 no frame from idle abort", busy_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) tick();
    t_reset();
    rst = 1'b0;
    tick();
    t_reset();
    t_single(16'hA5C3, 8'h00);
    t_single(16'hFFFF, 8'h00);
    t_single(16'h0001, 8'h00);
    t_single(16'h8000, 8'h00);
    t_single(16'h1234, 8'h01);
    t_single(16'h4321, 8'h80);
    t_gap_request();
    t_back_to_back();
    t_abort_mid();
    t_abort_last_edge();
    t_abort_pending();
    t_abort_idle();
    t_single(16'h6B2D, 8'h00);
    wait_idle();
    chk(bad_phase == 0, "R3 phase lengths", bad_phase, 0);
    chk(bad_valid == 0, "R5 valid only at cs rise", bad_valid, 0);
    chk(bad_idle == 0, "R12 sclk low while cs high", bad_idle, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule